// File: doc/BRIEF.md
# Quench Telemetry Frame Receiver

This block listens to the serial byte stream that one remote voltage-tap interface sends and turns it into sample records. It only receives; nothing in it drives the line, so it can sit as a passive listener beside another consumer of the same stream. Every remote interface runs on its own sample clock, so each instance keeps its own frame timing and needs nothing from any other channel. The line runs 8N1 at a nominal 230.4 kbaud, and a frame arrives about every 10 ms.

A frame holds 13 bytes, indexed from 0. Bytes 0 and 1 are a fixed sync pair. Byte 2 is a status byte. Bytes 3 to 10 hold four 16-bit fields, each sent high byte first, in this order: check time, quench duration time, raw ADC value, threshold. Bytes 11 and 12 hold a check code. The receiver oversamples the line, finds the sync pair, collects the fields and checks the code. A frame that passes updates the record outputs and gives a one-cycle valid pulse. A frame that fails gives a one-cycle error pulse that carries an error kind. A watchdog reports a lost link when valid frames stop arriving.

Top module: `qfr_rx_top`

## Requirements
- R1: Each byte is received 8N1 with the least significant bit first. The line is sampled OVS times per bit, one sample per tick. A tick occurs every TICK_DIV clocks. Each bit takes the majority of samples 7, 8 and 9, counted from the first low sample of the start bit. A one-sample glitch at mid-bit does not change the received byte.
- R2: A frame starts only after byte 0x80 and then byte 0x08. When the second byte is wrong, the search goes on from the next byte. When the second byte is 0x80 again, that byte counts as a new first sync byte. Bytes that arrive outside a frame produce neither a record nor an error.
- R3: A valid frame drives recStatus from byte 2. It drives recCheckTime from bytes 3 and 4, recQuenchTime from bytes 5 and 6, recAdcRaw from bytes 7 and 8 and recThreshold from bytes 9 and 10. In each field the first byte of the pair is the upper byte.
- R4: Byte 11 must equal the sum modulo 256 of bytes 0 to 10. Byte 12 must equal the bitwise inverse of byte 11. If either fails, errStrobe pulses with errKind 1 and the record outputs keep their previous values.
- R5: recValid is a one-cycle pulse for each accepted frame. The record outputs change only in the cycle in which recValid is high.
- R6: A stop bit sampled low gives an errStrobe pulse with errKind 2. Any frame in progress is dropped, and the record outputs keep their values.
- R7: Inside a frame, if GAP_TICKS ticks pass with no new byte, errStrobe pulses with errKind 3 and the partial frame is dropped. A frame whose byte spacing stays under that limit is accepted.
- R8: linkLost rises after WDOG_TICKS ticks without an accepted frame, counted from reset or from the last accepted frame. It falls in the same cycle that recValid is raised.
- R9: After reset, recValid, errStrobe and linkLost are low, errKind is 0 and all record outputs are zero.
- R10: recValid and errStrobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxIn | input | 1 | Serial line, idle high |
| recValid | output | 1 | One-cycle pulse: a new record is on the outputs |
| recStatus | output | 8 | Status byte of the last accepted frame |
| recCheckTime | output | 16 | Check time field |
| recQuenchTime | output | 16 | Quench duration time field |
| recAdcRaw | output | 16 | Raw ADC field |
| recThreshold | output | 16 | Threshold field |
| errStrobe | output | 1 | One-cycle pulse: a frame or byte was rejected |
| errKind | output | 2 | Reason for rejection: 1 check code, 2 stop bit, 3 gap |
| linkLost | output | 1 | No valid frame within the watchdog window |

## Verification
The assertions check, on every cycle, the rules that hold at any moment. Valid and error pulses never overlap. recValid lasts one cycle. The record stays fixed between valid pulses. A low stop bit is always reported as kind 2 on the next cycle. linkLost is low whenever a record is published. The bench scenarios cover what needs a stimulus history. These are the field order and byte order, the sync search after decoy bytes, both kinds of check-code corruption, the mid-bit glitches, the gap limit on both sides, and the watchdog window on both sides of its limit.

// File: rtl/qfr_pkg.sv
package qfr_pkg;
  localparam logic [7:0] SYNC_HI    = 8'h80;
  localparam logic [7:0] SYNC_LO    = 8'h08;
  localparam int         NUM_FIELDS = 4;
  localparam int         FRAME_LEN  = 2 + 1 + 2 * NUM_FIELDS + 2;
  localparam int         IDX_STATUS = 2;
  localparam int         IDX_SUM    = FRAME_LEN - 2;
  localparam int         IDX_INV    = FRAME_LEN - 1;
  localparam int         IDX_W      = $clog2(FRAME_LEN);

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_SUM  = 2'd1,
    ERR_STOP = 2'd2,
    ERR_GAP  = 2'd3
  } errKind_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic             restart;
    logic             load;
    logic [IDX_W-1:0] idx;
    logic             publish;
  } dpCtrl_t;
endpackage

// File: rtl/qfr_uart_rx.sv
module qfr_uart_rx #(
  parameter int TICK_DIV = 34,
  parameter int OVS      = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxIn,
  output logic       tick,
  output logic       byteValid,
  output logic       stopErr,
  output logic [7:0] byteData
);
  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam int PH_W  = $clog2(OVS);
  localparam int MID   = OVS / 2 + 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rxState_t;

  rxState_t         st;
  logic [1:0]       syncQ;
  logic             rxS;
  logic [DIV_W-1:0] divCnt;
  logic [PH_W-1:0]  phase;
  logic [1:0]       win;
  logic [2:0]       bitCnt;
  logic [7:0]       shReg;
  logic             vote;

  assign rxS      = syncQ[1];
  assign tick     = (divCnt == DIV_W'(TICK_DIV - 1));
  assign vote     = (win[1] & win[0]) | (win[1] & rxS) | (win[0] & rxS);
  assign byteData = shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      divCnt <= '0;
    end else begin
      syncQ  <= {syncQ[0], rxIn};
      divCnt <= tick ? '0 : divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= S_IDLE;
      phase     <= '0;
      win       <= 2'b11;
      bitCnt    <= '0;
      shReg     <= '0;
      byteValid <= 1'b0;
      stopErr   <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      stopErr   <= 1'b0;
      if (tick) begin
        win <= {win[0], rxS};
        if (st == S_IDLE) begin
          if (!rxS) begin
            st    <= S_START;
            phase <= PH_W'(1);
          end
        end else begin
          phase <= (phase == PH_W'(OVS - 1)) ? '0 : phase + 1'b1;
          if (phase == PH_W'(MID)) begin
            case (st)
              S_START: begin
                st     <= vote ? S_IDLE : S_DATA;
                bitCnt <= '0;
              end
              S_DATA: begin
                shReg  <= {vote, shReg[7:1]};
                bitCnt <= bitCnt + 1'b1;
                if (bitCnt == 3'd7) st <= S_STOP;
              end
              default: begin
                st        <= S_IDLE;
                byteValid <= vote;
                stopErr   <= !vote;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/qfr_frame_dp.sv
module qfr_frame_dp
  import qfr_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCtrl_t                      ctl,
  input  logic [7:0]                   byteData,
  output logic                         sumOk,
  output logic [7:0]                   recStatus,
  output logic [NUM_FIELDS-1:0][15:0]  recField
);
  logic [7:0] sumAcc;
  logic [7:0] base;
  logic [7:0] shadow [IDX_STATUS:IDX_SUM];

  assign base  = ctl.restart ? 8'h00 : sumAcc;
  assign sumOk = (shadow[IDX_SUM] == sumAcc) && (byteData == ~sumAcc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumAcc <= '0;
      for (int i = IDX_STATUS; i <= IDX_SUM; i++) shadow[i] <= '0;
    end else if (ctl.load) begin
      if (ctl.idx < IDX_W'(IDX_SUM)) sumAcc <= base + byteData;
      if (ctl.idx >= IDX_W'(IDX_STATUS) && ctl.idx <= IDX_W'(IDX_SUM))
        shadow[ctl.idx] <= byteData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            recStatus <= '0;
    else if (ctl.publish) recStatus <= shadow[IDX_STATUS];
  end

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic [15:0] fieldQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            fieldQ <= '0;
      else if (ctl.publish) fieldQ <= {shadow[IDX_STATUS + 1 + 2 * f],
                                       shadow[IDX_STATUS + 2 + 2 * f]};
    end
    assign recField[f] = fieldQ;
  end
endmodule

// File: rtl/qfr_frame_ctrl.sv
module qfr_frame_ctrl
  import qfr_pkg::*;
#(
  parameter int GAP_TICKS  = 7373,
  parameter int WDOG_TICKS = 110592
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       byteValid,
  input  logic       stopErr,
  input  logic [7:0] byteData,
  input  logic       sumOk,
  output dpCtrl_t    ctl,
  output logic       recValid,
  output logic       errStrobe,
  output logic [1:0] errKind,
  output logic       linkLost
);
  localparam int GAP_W = $clog2(GAP_TICKS + 1);
  localparam int WD_W  = $clog2(WDOG_TICKS + 1);

  typedef enum logic [1:0] {H_FIRST, H_SECOND, H_BODY} syncState_t;

  syncState_t       st, nxtSt;
  logic [IDX_W-1:0] nextIdx, nxtIdx;
  logic [GAP_W-1:0] gapCnt;
  logic [WD_W-1:0]  wdCnt;
  logic             gapHit, pub, errNow;
  errKind_t         kind;

  assign gapHit = tick && (st != H_FIRST) && (gapCnt == GAP_W'(GAP_TICKS - 1));

  always_comb begin
    ctl    = '0;
    nxtSt  = st;
    nxtIdx = nextIdx;
    pub    = 1'b0;
    errNow = 1'b0;
    kind   = ERR_NONE;
    if (stopErr) begin
      nxtSt  = H_FIRST;
      errNow = 1'b1;
      kind   = ERR_STOP;
    end else if (byteValid) begin
      case (st)
        H_FIRST: begin
          if (byteData == SYNC_HI) begin
            ctl.restart = 1'b1;
            ctl.load    = 1'b1;
            nxtSt       = H_SECOND;
          end
        end
        H_SECOND: begin
          if (byteData == SYNC_LO) begin
            ctl.load = 1'b1;
            ctl.idx  = IDX_W'(1);
            nxtSt    = H_BODY;
            nxtIdx   = IDX_W'(IDX_STATUS);
          end else if (byteData == SYNC_HI) begin
            ctl.restart = 1'b1;
            ctl.load    = 1'b1;
          end else begin
            nxtSt = H_FIRST;
          end
        end
        default: begin
          ctl.load = 1'b1;
          ctl.idx  = nextIdx;
          nxtIdx   = nextIdx + 1'b1;
          if (nextIdx == IDX_W'(IDX_INV)) begin
            nxtSt = H_FIRST;
            if (sumOk) begin
              ctl.publish = 1'b1;
              pub         = 1'b1;
            end else begin
              errNow = 1'b1;
              kind   = ERR_SUM;
            end
          end
        end
      endcase
    end else if (gapHit) begin
      nxtSt  = H_FIRST;
      errNow = 1'b1;
      kind   = ERR_GAP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= H_FIRST;
      nextIdx   <= '0;
      gapCnt    <= '0;
      recValid  <= 1'b0;
      errStrobe <= 1'b0;
      errKind   <= ERR_NONE;
    end else begin
      st        <= nxtSt;
      nextIdx   <= nxtIdx;
      recValid  <= pub;
      errStrobe <= errNow;
      errKind   <= kind;
      if (byteValid || stopErr || nxtSt == H_FIRST) gapCnt <= '0;
      else if (tick)                                gapCnt <= gapCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt    <= '0;
      linkLost <= 1'b0;
    end else if (pub) begin
      wdCnt    <= '0;
      linkLost <= 1'b0;
    end else if (tick && !linkLost) begin
      if (wdCnt == WD_W'(WDOG_TICKS - 1)) linkLost <= 1'b1;
      else                                 wdCnt    <= wdCnt + 1'b1;
    end
  end
endmodule

// File: rtl/qfr_rx_top.sv
module qfr_rx_top
  import qfr_pkg::*;
#(
  parameter int TICK_DIV   = 34,
  parameter int OVS        = 16,
  parameter int GAP_TICKS  = 7373,
  parameter int WDOG_TICKS = 110592
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxIn,
  output logic        recValid,
  output logic [7:0]  recStatus,
  output logic [15:0] recCheckTime,
  output logic [15:0] recQuenchTime,
  output logic [15:0] recAdcRaw,
  output logic [15:0] recThreshold,
  output logic        errStrobe,
  output logic [1:0]  errKind,
  output logic        linkLost
);
  logic                        tick, byteValid, stopErr, sumOk;
  logic [7:0]                  byteData;
  dpCtrl_t                     ctl;
  logic [NUM_FIELDS-1:0][15:0] recField;

  qfr_uart_rx #(.TICK_DIV(TICK_DIV), .OVS(OVS)) u_uart (
    .clk, .rstN, .rxIn, .tick, .byteValid, .stopErr, .byteData
  );

  qfr_frame_ctrl #(.GAP_TICKS(GAP_TICKS), .WDOG_TICKS(WDOG_TICKS)) u_ctrl (
    .clk, .rstN, .tick, .byteValid, .stopErr, .byteData, .sumOk,
    .ctl, .recValid, .errStrobe, .errKind, .linkLost
  );

  qfr_frame_dp u_dp (
    .clk, .rstN, .ctl, .byteData, .sumOk, .recStatus, .recField
  );

  assign recCheckTime  = recField[0];
  assign recQuenchTime = recField[1];
  assign recAdcRaw     = recField[2];
  assign recThreshold  = recField[3];
endmodule

// File: rtl/qfr_rx_checker.sv
module qfr_rx_checker (
  input logic        clk,
  input logic        rstN,
  input logic        recValid,
  input logic        errStrobe,
  input logic [1:0]  errKind,
  input logic        linkLost,
  input logic [7:0]  recStatus,
  input logic [15:0] recCheckTime,
  input logic [15:0] recQuenchTime,
  input logic [15:0] recAdcRaw,
  input logic [15:0] recThreshold,
  input logic        byteValid,
  input logic        stopErr
);
  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(recValid && errStrobe));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    recValid |=> !recValid);

  a_r5_record_held: assert property (@(posedge clk) disable iff (!rstN)
    !recValid |-> ($stable(recStatus) && $stable(recCheckTime) && $stable(recQuenchTime)
                   && $stable(recAdcRaw) && $stable(recThreshold)));

  a_r8_clear_on_record: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> !linkLost);

  a_r4_kind_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    errStrobe |-> (errKind != 2'd0));

  a_r1_byte_or_stop: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({byteValid, stopErr}));

  a_r6_stop_reported: assert property (@(posedge clk) disable iff (!rstN)
    stopErr |=> (errStrobe && errKind == 2'd2));
endmodule

bind qfr_rx_top qfr_rx_checker u_chk (
  .clk(clk), .rstN(rstN), .recValid(recValid), .errStrobe(errStrobe),
  .errKind(errKind), .linkLost(linkLost), .recStatus(recStatus),
  .recCheckTime(recCheckTime), .recQuenchTime(recQuenchTime),
  .recAdcRaw(recAdcRaw), .recThreshold(recThreshold),
  .byteValid(byteValid), .stopErr(stopErr)
);

// File: tb/qfr_rx_top_bench.sv
module qfr_rx_top_bench;
  localparam int TD    = 2;
  localparam int OVS   = 16;
  localparam int GAP   = 400;
  localparam int WDOG  = 5000;
  localparam int BIT_C = OVS * TD;

  typedef logic [7:0] frame_t [13];

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic recValid, errStrobe, linkLost;
  logic [7:0] recStatus;
  logic [15:0] recCheckTime, recQuenchTime, recAdcRaw, recThreshold;
  logic [1:0] errKind;

  int checks = 0;
  int bad = 0;
  logic [71:0] expRec[$];
  logic [1:0]  expErr[$];
  logic [71:0] lastGood = '0;

  always #4 clk = ~clk;

  qfr_rx_top #(.TICK_DIV(TD), .OVS(OVS), .GAP_TICKS(GAP), .WDOG_TICKS(WDOG)) u_qfr_rx_top (
    .clk, .rstN, .rxIn, .recValid, .recStatus, .recCheckTime, .recQuenchTime,
    .recAdcRaw, .recThreshold, .errStrobe, .errKind, .linkLost
  );

  function automatic logic [71:0] gotRec();
    return {recStatus, recCheckTime, recQuenchTime, recAdcRaw, recThreshold};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [71:0] got, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference: every output pulse must match the next expected event
  always @(negedge clk) if (rstN) begin
    if (recValid) begin
      if (expRec.size() == 0) check(0, "R5 unexpected record", gotRec(), 0);
      else begin
        logic [71:0] e;
        e = expRec.pop_front();
        check(gotRec() == e, "R3 record fields", gotRec(), e);
        lastGood = e;
      end
    end
    if (errStrobe) begin
      if (expErr.size() == 0) check(0, "R10 unexpected error", 72'(errKind), 0);
      else begin
        logic [1:0] k;
        k = expErr.pop_front();
        check(errKind == k, (k == 2'd1) ? "R4 kind" : (k == 2'd2) ? "R6 kind" : "R7 kind",
              72'(errKind), 72'(k));
      end
    end
  end

  function automatic frame_t buildFrame(input logic [7:0] st, input logic [15:0] a, b, c, d);
    frame_t f;
    logic [7:0] s;
    f[0] = 8'h80; f[1] = 8'h08; f[2] = st;
    f[3] = a[15:8]; f[4] = a[7:0]; f[5] = b[15:8]; f[6] = b[7:0];
    f[7] = c[15:8]; f[8] = c[7:0]; f[9] = d[15:8]; f[10] = d[7:0];
    s = 8'h00;
    for (int i = 0; i < 11; i++) s = s + f[i];
    f[11] = s;
    f[12] = ~s;
    return f;
  endfunction

  task automatic hold(input logic v, input int n);
    rxIn = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic v, input bit glitch);
    if (glitch) begin
      hold(v, 8 * TD); hold(~v, TD); hold(v, 7 * TD);
    end else hold(v, BIT_C);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit stopOk, input bit glitch);
    sendBit(1'b0, glitch);
    for (int i = 0; i < 8; i++) sendBit(b[i], glitch);
    sendBit(stopOk, 1'b0);
  endtask

  task automatic idleTicks(input int n);
    hold(1'b1, n * TD);
  endtask

  task automatic sendFrame(input frame_t f, input int spaceTicks, input bit glitch);
    for (int i = 0; i < 13; i++) begin
      sendByte(f[i], 1'b1, glitch);
      if (spaceTicks > 0) idleTicks(spaceTicks);
    end
    idleTicks(4);
  endtask

  task automatic expectGood(input logic [7:0] st, input logic [15:0] a, b, c, d);
    expRec.push_back({st, a, b, c, d});
  endtask

  task automatic drained(input string tag);
    check(expRec.size() == 0 && expErr.size() == 0, tag,
          72'(expRec.size()), 72'(expErr.size()));
  endtask

  initial begin
    frame_t f;
    repeat (5) @(negedge clk);
    // R9 reset state
    check(!recValid && !errStrobe && !linkLost && errKind == 2'd0 && gotRec() == '0,
          "R9 reset state", gotRec(), 0);
    rstN = 1'b1;
    idleTicks(20);

    // R3 two frames back to back, distinct patterns
    expectGood(8'h5A, 16'h1234, 16'hABCD, 16'h00FF, 16'hFF00);
    sendFrame(buildFrame(8'h5A, 16'h1234, 16'hABCD, 16'h00FF, 16'hFF00), 0, 0);
    drained("R3 first frame");
    expectGood(8'h80, 16'h0880, 16'h8008, 16'hFFFF, 16'h0001);
    sendFrame(buildFrame(8'h80, 16'h0880, 16'h8008, 16'hFFFF, 16'h0001), 0, 0);
    drained("R3 second frame");

    // R2 decoys: lone 0x08, 0x80 then wrong byte, repeated 0x80 before the real pair
    sendByte(8'h08, 1, 0); sendByte(8'h80, 1, 0); sendByte(8'h55, 1, 0);
    sendByte(8'h80, 1, 0); sendByte(8'h80, 1, 0);
    expectGood(8'hC3, 16'h0102, 16'h0304, 16'h0506, 16'h0708);
    sendFrame(buildFrame(8'hC3, 16'h0102, 16'h0304, 16'h0506, 16'h0708), 0, 0);
    drained("R2 resync");

    // R4 corrupt sum byte, then corrupt inverse byte
    f = buildFrame(8'h11, 16'h2222, 16'h3333, 16'h4444, 16'h5555);
    f[11] = f[11] ^ 8'h01;
    expErr.push_back(2'd1);
    sendFrame(f, 0, 0);
    drained("R4 sum byte");
    check(gotRec() == lastGood, "R4 record held", gotRec(), lastGood);
    f = buildFrame(8'h11, 16'h2222, 16'h3333, 16'h4444, 16'h5555);
    f[12] = f[12] ^ 8'h40;
    expErr.push_back(2'd1);
    sendFrame(f, 0, 0);
    drained("R4 inverse byte");
    check(gotRec() == lastGood, "R4 record held", gotRec(), lastGood);

    // R6 low stop bit mid frame
    f = buildFrame(8'h22, 16'h6666, 16'h7777, 16'h8888, 16'h9999);
    for (int i = 0; i < 5; i++) sendByte(f[i], 1, 0);
    expErr.push_back(2'd2);
    sendByte(f[5], 0, 0);
    idleTicks(20);
    drained("R6 stop error");
    check(gotRec() == lastGood, "R6 record held", gotRec(), lastGood);
    expectGood(8'h33, 16'hDEAD, 16'hBEEF, 16'h0F0F, 16'hF0F0);
    sendFrame(buildFrame(8'h33, 16'hDEAD, 16'hBEEF, 16'h0F0F, 16'hF0F0), 0, 0);
    drained("R6 recovery");

    // R7 gap over the limit aborts, spaced bytes under the limit pass
    f = buildFrame(8'h44, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    for (int i = 0; i < 5; i++) sendByte(f[i], 1, 0);
    expErr.push_back(2'd3);
    idleTicks(GAP + 50);
    drained("R7 gap abort");
    check(gotRec() == lastGood, "R7 record held", gotRec(), lastGood);
    expectGood(8'h66, 16'h0A0B, 16'h0C0D, 16'h0E0F, 16'h1011);
    sendFrame(buildFrame(8'h66, 16'h0A0B, 16'h0C0D, 16'h0E0F, 16'h1011), 150, 0);
    drained("R7 spaced frame");

    // R1 glitch on every bit
    expectGood(8'h96, 16'h6996, 16'hA55A, 16'h3CC3, 16'h7EE7);
    sendFrame(buildFrame(8'h96, 16'h6996, 16'hA55A, 16'h3CC3, 16'h7EE7), 0, 1);
    drained("R1 glitch frame");

    // R8 watchdog just inside and past its window
    idleTicks(WDOG - 300);
    check(!linkLost, "R8 inside window", 72'(linkLost), 0);
    idleTicks(400);
    check(linkLost, "R8 past window", 72'(linkLost), 1);
    expectGood(8'h01, 16'h0002, 16'h0003, 16'h0004, 16'h0005);
    sendFrame(buildFrame(8'h01, 16'h0002, 16'h0003, 16'h0004, 16'h0005), 0, 0);
    drained("R8 frame after loss");
    check(!linkLost, "R8 cleared", 72'(linkLost), 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule